// File: doc/BRIEF.md
# Shared Issue Queue Occupancy Allocator

This block keeps one occupancy counter per hardware thread for a shared issue queue and decides, cycle by cycle, whether each thread may place another instruction into it. Every thread sees the same per-thread cap. A static parameter picks how that cap is set. Under dynamic sharing the cap is the whole queue. Under equal partitioning the queue is split evenly across the threads that are currently active. Under threshold sharing each thread may hold a fixed percentage of the queue, except that a thread running alone may use all of it.

Rename or dispatch logic raises an insert request for a thread and reads the per-thread full flag in the same cycle. Issue-and-commit or squash logic pulses a release line once for each entry it frees. The active-thread mask is sampled on every clock, and the cap follows it one cycle later. A per-thread free count and a global free count let upstream logic size its dispatch group.

Top module: `iq_share_alloc`

## Requirements
- R1: While reset is held and before the first insert, every counter is zero, `glob_free_o` equals NUM_ENTRIES and no `full_o` bit is set.
- R2: A granted insert increments its thread's count at the next clock edge, so `glob_free_o` falls by one.
- R3: A release pulse decrements its thread's count at the next edge. A release to a thread whose count is zero is ignored.
- R4: A granted insert and a release for the same thread in the same cycle leave that thread's count unchanged.
- R5: `full_o[t]` is high when `glob_free_o` is zero or when thread t's count is at or above the current cap. An insert request to a full thread is not counted, and `ins_err_o[t]` is high in the same cycle.
- R6: When several threads request in one cycle, grants go to the lowest-numbered non-full requesters first, and at most `glob_free_o` of them are granted. Every request that is not granted raises its `ins_err_o` bit. Releases in that cycle do not add capacity for it.
- R7: Dynamic policy: the cap is NUM_ENTRIES.
- R8: Partitioned policy: the cap is NUM_ENTRIES / n, rounded down, where n is the number of set bits of `active_i` at the previous clock edge. An n of zero counts as NUM_THREADS. After reset and before the first edge, n is taken to be NUM_THREADS.
- R9: Threshold policy: the cap is floor(NUM_ENTRIES*THRESH_PCT/100), but NUM_ENTRIES when exactly one thread was active at the previous edge. After reset and before the first edge, all threads are taken to be active.
- R10: `glob_free_o` is NUM_ENTRIES minus the sum of all thread counts. `thr_free_o[t]` is the smaller of `glob_free_o` and (cap minus count), and it is zero when the count is at or above the cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | NUM_THREADS | Mask of threads currently active |
| ins_req_i | input | NUM_THREADS | Insert request per thread |
| rel_i | input | NUM_THREADS | One-entry release pulse per thread |
| full_o | output | NUM_THREADS | Thread may not insert this cycle |
| ins_err_o | output | NUM_THREADS | Insert request refused this cycle |
| thr_free_o | output | NUM_THREADS x CW | Entries each thread may still take |
| glob_free_o | output | CW | Unused entries in the whole queue |

## Verification
A counter that drifts by one shows up in `glob_free_o` one cycle after the faulty edge. It then stays wrong until reset, because no later event corrects it. A wrong cap register, or a cap that ignores the active mask, shows up one cycle after the mask changes, as a wrong `full_o` or `thr_free_o` on the threads near their limit. Arbitration mistakes appear in the same cycle on `ins_err_o`, and they appear in `glob_free_o` one edge later. The bench runs three policy variants in lockstep on the same stimulus, so an error that only one policy path can produce is still caught.

// File: rtl/iq_share_pkg.sv
package iq_share_pkg;
  typedef enum logic [1:0] {
    SHARE_DYNAMIC   = 2'd0,
    SHARE_PARTITION = 2'd1,
    SHARE_THRESHOLD = 2'd2
  } share_pol_e;
endpackage

// File: rtl/iq_cap_calc.sv
module iq_cap_calc
  import iq_share_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned NUM_THREADS = 2,
  parameter share_pol_e  POLICY      = SHARE_THRESHOLD,
  parameter int unsigned THRESH_PCT  = 75,
  parameter int unsigned CW          = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] active_i,
  output logic [CW-1:0]          cap_o
);
  localparam int unsigned ACW     = $clog2(NUM_THREADS + 1);
  localparam int unsigned TAB_N   = 2 ** ACW;
  localparam int unsigned THR_CAP = NUM_ENTRIES * THRESH_PCT / 100;
  localparam int unsigned RST_CAP =
      (POLICY == SHARE_DYNAMIC)   ? NUM_ENTRIES :
      (POLICY == SHARE_PARTITION) ? NUM_ENTRIES / NUM_THREADS :
      (NUM_THREADS == 1)          ? NUM_ENTRIES : THR_CAP;

  logic [ACW-1:0] n_act;
  logic [CW-1:0]  cap_d, cap_q;
  logic [CW-1:0]  part_tab [TAB_N];

  always_comb begin
    n_act = '0;
    for (int i = 0; i < NUM_THREADS; i++) n_act = n_act + ACW'(active_i[i]);
  end

  // share table indexed by live active count; 0 or out of range -> all threads
  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    localparam int unsigned DIV = (k == 0 || k > NUM_THREADS) ? NUM_THREADS : k;
    assign part_tab[k] = CW'(NUM_ENTRIES / DIV);
  end

  if (POLICY == SHARE_DYNAMIC) begin : g_dyn
    assign cap_d = CW'(NUM_ENTRIES);
  end else if (POLICY == SHARE_PARTITION) begin : g_part
    assign cap_d = part_tab[n_act];
  end else begin : g_thr
    assign cap_d = (n_act == ACW'(1)) ? CW'(NUM_ENTRIES) : CW'(THR_CAP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= CW'(RST_CAP);
    else         cap_q <= cap_d;
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/iq_thread_ctr.sv
module iq_thread_ctr #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/iq_share_alloc.sv
module iq_share_alloc
  import iq_share_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned NUM_THREADS = 2,
  parameter share_pol_e  POLICY      = SHARE_THRESHOLD,
  parameter int unsigned THRESH_PCT  = 75,
  localparam int unsigned CW         = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_THREADS-1:0]          active_i,
  input  logic [NUM_THREADS-1:0]          ins_req_i,
  input  logic [NUM_THREADS-1:0]          rel_i,
  output logic [NUM_THREADS-1:0]          full_o,
  output logic [NUM_THREADS-1:0]          ins_err_o,
  output logic [NUM_THREADS-1:0][CW-1:0]  thr_free_o,
  output logic [CW-1:0]                   glob_free_o
);
  localparam int unsigned SW = CW + $clog2(NUM_THREADS) + 1;

  logic [CW-1:0]                  cap;
  logic [NUM_THREADS-1:0][CW-1:0] cnt;
  logic [NUM_THREADS-1:0]         grant;
  logic [SW-1:0]                  occ_sum;

  iq_cap_calc #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS),
    .POLICY(POLICY), .THRESH_PCT(THRESH_PCT), .CW(CW)
  ) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i), .cap_o(cap)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    iq_thread_ctr #(.CW(CW)) u_ctr (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .inc_i(grant[t]), .dec_i(rel_i[t]), .cnt_o(cnt[t])
    );

    logic [CW-1:0] head;
    assign head          = (cap > cnt[t]) ? (cap - cnt[t]) : '0;
    assign full_o[t]     = (glob_free_o == '0) || (cnt[t] >= cap);
    assign thr_free_o[t] = (head < glob_free_o) ? head : glob_free_o;
  end

  always_comb begin
    occ_sum = '0;
    for (int t = 0; t < NUM_THREADS; t++) occ_sum = occ_sum + SW'(cnt[t]);
  end

  assign glob_free_o = CW'(SW'(NUM_ENTRIES) - occ_sum);

  // fixed priority, lowest thread first, bounded by global free space
  always_comb begin
    logic [CW-1:0] taken;
    taken = '0;
    grant = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (ins_req_i[t] && !full_o[t] && (taken < glob_free_o)) begin
        grant[t] = 1'b1;
        taken    = taken + CW'(1);
      end
    end
  end

  assign ins_err_o = ins_req_i & ~grant;
endmodule

// File: rtl/iq_share_alloc_chk.sv
module iq_share_alloc_chk
  import iq_share_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned NUM_THREADS = 2,
  parameter share_pol_e  POLICY      = SHARE_THRESHOLD,
  parameter int unsigned CW          = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_THREADS-1:0]         ins_req_i,
  input logic [NUM_THREADS-1:0]         rel_i,
  input logic [NUM_THREADS-1:0]         full_o,
  input logic [NUM_THREADS-1:0]         ins_err_o,
  input logic [NUM_THREADS-1:0][CW-1:0] thr_free_o,
  input logic [CW-1:0]                  glob_free_o
);
  p_glob_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_free_o <= CW'(NUM_ENTRIES));

  p_all_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glob_free_o == '0) |-> (&full_o));

  p_grant_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ins_req_i & ~ins_err_o) <= int'(glob_free_o));

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ins_req_i & ~ins_err_o) == '0 && rel_i == '0) |=> $stable(glob_free_o));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
    p_err_on_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ins_req_i[t] && full_o[t]) |-> ins_err_o[t]);

    p_thr_le_glob_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      thr_free_o[t] <= glob_free_o);

    p_single_insert_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ins_req_i == (NUM_THREADS'(1) << t) && !ins_err_o[t] && rel_i == '0)
      |=> (glob_free_o == $past(glob_free_o) - CW'(1)));

    if (POLICY == SHARE_DYNAMIC) begin : g_dyn
      p_dyn_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thr_free_o[t] == glob_free_o);
    end
  end
endmodule

bind iq_share_alloc iq_share_alloc_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS), .POLICY(POLICY), .CW(CW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ins_req_i(ins_req_i), .rel_i(rel_i),
  .full_o(full_o), .ins_err_o(ins_err_o), .thr_free_o(thr_free_o),
  .glob_free_o(glob_free_o)
);

// File: tb/iq_share_alloc_tb.sv
module iq_share_alloc_tb;
  import iq_share_pkg::*;
  localparam int E  = 8;
  localparam int NT = 2;
  localparam int PCT = 75;
  localparam int CW = $clog2(E + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] active = '1;
  logic [NT-1:0] ins_req = '0;
  logic [NT-1:0] rel = '0;

  logic [NT-1:0]         full_w [3];
  logic [NT-1:0]         err_w  [3];
  logic [NT-1:0][CW-1:0] tf_w   [3];
  logic [CW-1:0]         gf_w   [3];

  int n_tests = 0, n_fail = 0, cyc_cnt = 0;
  int m_cnt [3][NT];
  int m_cap [3];
  logic [NT-1:0] last_err [3];

  always #5 clk = ~clk;

  iq_share_alloc #(.NUM_ENTRIES(E), .NUM_THREADS(NT), .POLICY(SHARE_THRESHOLD), .THRESH_PCT(PCT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .active_i(active), .ins_req_i(ins_req), .rel_i(rel),
    .full_o(full_w[0]), .ins_err_o(err_w[0]), .thr_free_o(tf_w[0]), .glob_free_o(gf_w[0]));
  iq_share_alloc #(.NUM_ENTRIES(E), .NUM_THREADS(NT), .POLICY(SHARE_PARTITION), .THRESH_PCT(PCT)) u_dut_part (
    .clk_i(clk), .rst_ni(rst_n), .active_i(active), .ins_req_i(ins_req), .rel_i(rel),
    .full_o(full_w[1]), .ins_err_o(err_w[1]), .thr_free_o(tf_w[1]), .glob_free_o(gf_w[1]));
  iq_share_alloc #(.NUM_ENTRIES(E), .NUM_THREADS(NT), .POLICY(SHARE_DYNAMIC), .THRESH_PCT(PCT)) u_dut_dyn (
    .clk_i(clk), .rst_ni(rst_n), .active_i(active), .ins_req_i(ins_req), .rel_i(rel),
    .full_o(full_w[2]), .ins_err_o(err_w[2]), .thr_free_o(tf_w[2]), .glob_free_o(gf_w[2]));

  // k: 0 threshold (R9), 1 partitioned (R8), 2 dynamic (R7)
  function automatic int cap_of(int k, logic [NT-1:0] act);
    int n = $countones(act);
    if (k == 2) return E;
    if (k == 1) return E / ((n == 0) ? NT : n);
    return (n == 1) ? E : (E * PCT / 100);
  endfunction

  function automatic string pol_tag(int k);
    return (k == 0) ? "R9" : (k == 1) ? "R8" : "R7";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [NT-1:0] ins, input logic [NT-1:0] rl);
    bit gr [3][NT];
    ins_req = ins;
    rel = rl;
    #1;
    for (int k = 0; k < 3; k++) begin
      int gf = E, acc = 0;
      for (int i = 0; i < NT; i++) gf -= m_cnt[k][i];
      check("R10", "glob_free", int'(gf_w[k]), gf);
      for (int i = 0; i < NT; i++) begin
        bit fe = (gf == 0) || (m_cnt[k][i] >= m_cap[k]);
        int hd = (m_cap[k] > m_cnt[k][i]) ? m_cap[k] - m_cnt[k][i] : 0;
        gr[k][i] = ins[i] && !fe && (acc < gf);
        if (gr[k][i]) acc++;
        check(pol_tag(k), "full", int'(full_w[k][i]), int'(fe));
        check("R10", "thr_free", int'(tf_w[k][i]), (hd < gf) ? hd : gf);
        check(fe ? "R5" : "R6", "ins_err", int'(err_w[k][i]), int'(ins[i] && !gr[k][i]));
      end
      last_err[k] = err_w[k];
    end
    @(posedge clk);
    cyc_cnt++;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < NT; i++) begin
        if (gr[k][i] && !rl[i]) m_cnt[k][i]++;
        else if (!gr[k][i] && rl[i] && m_cnt[k][i] > 0) m_cnt[k][i]--;
      end
      m_cap[k] = cap_of(k, active);
    end
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) begin
      m_cap[k] = cap_of(k, '1);
      for (int i = 0; i < NT; i++) m_cnt[k][i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int k = 0; k < 3; k++) begin
      check("R1", "glob_free in reset", int'(gf_w[k]), E);
      check("R1", "full in reset", int'(full_w[k]), 0);
    end
    rst_n = 1'b1;
    #1;
    check("R1", "glob_free after reset", int'(gf_w[0]), E);

    cyc(2'b01, 2'b00);
    check("R2", "glob_free after one insert", int'(gf_w[0]), 7);
    cyc(2'b01, 2'b01);
    check("R4", "insert+release same thread", int'(gf_w[0]), 7);
    cyc(2'b00, 2'b10);
    check("R3", "release on empty thread", int'(gf_w[0]), 7);
    cyc(2'b00, 2'b01);
    check("R3", "release decrements", int'(gf_w[0]), 8);
    repeat (6) cyc(2'b01, 2'b00);
    check("R9", "thread0 full at threshold cap 6", int'(full_w[0][0]), 1);
    cyc(2'b01, 2'b00);
    check("R5", "insert on full flagged", int'(last_err[0][0]), 1);
    check("R5", "insert on full ignored", int'(gf_w[0]), 2);

    active = 2'b01;
    cyc(2'b00, 2'b00);
    check("R9", "single active thread gets whole queue", int'(tf_w[0][0]), 2);
    check("R8", "partition with one active", int'(tf_w[1][0]), 4);
    cyc(2'b01, 2'b00);
    check("R2", "insert up to last entry", int'(gf_w[0]), 1);
    cyc(2'b11, 2'b00);
    check("R6", "lower thread wins last entry", int'(last_err[0]), 2);
    check("R5", "queue empty of free entries", int'(gf_w[0]), 0);
    check("R5", "all threads full", int'(full_w[0]), 3);

    active = 2'b11;
    for (int n = 0; n < 800; n++) begin
      logic [NT-1:0] r;
      if ($urandom_range(0, 7) == 0) active = NT'($urandom);
      else if ($urandom_range(0, 7) == 0) active = '1;
      for (int i = 0; i < NT; i++) r[i] = ($urandom_range(0, 2) == 0);
      cyc(NT'($urandom), r);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule